// File: doc/BRIEF.md
# Consecutive-Event Fault Queue Filter

This block is the noise filter between the per-zone threshold comparison and the status logic of a multi-zone temperature supervisor. Every time a zone completes a conversion, the measured value is compared as a signed number with that zone's high and low limits. A zone reports a qualified high (or low) event only after a run of back-to-back out-of-limit conversions. The run must be as long as the depth chosen by a two-bit field. One in-limit conversion ends the run and clears the event.

Each zone keeps separate run counters for the high and low conditions. A counter saturates at the configured depth, so a qualified event stays asserted while the condition persists. The queues are purged by register writes. A configuration write clears every zone. A write to either limit register of a zone clears only that zone. Critical and diode-fault indications are not filtered: they are captured on the first conversion that reports them.

Top module: `fault_queue_filter`

## Requirements
- R1: A conversion whose value is strictly greater than the zone's high limit, compared as signed two's complement, is a high candidate. A value equal to the limit is not a candidate.
- R2: A conversion whose value is strictly less than the zone's low limit, compared as signed, is a low candidate. Example: -1.0625 degrees is below a limit of -1.0.
- R3: `depth_sel` encodes the run length as 00 = 1 (the reset default), 01 = 2, 10 = 4 and 11 = 6. An event output rises in the cycle after the conversion that completes the run.
- R4: A conversion that is not a candidate restarts that condition's run and deasserts its event output in the next cycle.
- R5: While candidates keep arriving, a qualified event stays asserted and its counter does not pass the depth.
- R6: A pulse on `cfg_wr` purges both run counters of every zone, and all event outputs read 0 in the next cycle.
- R7: A pulse on `hi_lim_wr[z]` or `lo_lim_wr[z]` purges only zone z. The run counts of other zones are kept.
- R8: When a purge and a conversion strobe occur in the same cycle, the purge wins and the conversion is not counted.
- R9: `crit_evt[z]` and `diode_evt[z]` take the values of `crit_raw[z]` and `diode_raw[z]` in the cycle after each conversion of zone z, whatever the depth.
- R10: In cycles without a conversion strobe or a purge, every output holds its value, even when the temperature inputs change.
- R11: After reset, all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | NZONE | Per-zone conversion-complete strobe |
| temp_flat | input | NZONE*TW | Measured values; zone z in bits [z*TW +: TW], signed, 4 fraction bits |
| hi_lim_flat | input | NZONE*TW | High limits, same layout |
| lo_lim_flat | input | NZONE*TW | Low limits, same layout |
| depth_sel | input | 2 | Queue depth code |
| cfg_wr | input | 1 | Configuration register write strobe (purges all zones) |
| hi_lim_wr | input | NZONE | High-limit write strobe per zone |
| lo_lim_wr | input | NZONE | Low-limit write strobe per zone |
| crit_raw | input | NZONE | Unfiltered critical indication per zone |
| diode_raw | input | NZONE | Unfiltered diode-fault indication per zone |
| hi_evt | output | NZONE | Qualified high event |
| lo_evt | output | NZONE | Qualified low event |
| crit_evt | output | NZONE | Captured critical indication |
| diode_evt | output | NZONE | Captured diode-fault indication |

## Verification
Every result is one register away from its cause. Event, critical and diode outputs change at the clock edge that samples the strobe or the purge, so they are valid one cycle after it. The bench drives stimulus on the falling edge and reads the outputs on the next falling edge, after exactly one rising edge. For a run of depth N, it checks the output after each of the N strobes. It expects 0 after the first N-1 strobes and 1 only after the Nth. For hold behaviour, it waits several idle cycles before reading.

// File: rtl/fq_pkg.sv
// Package: shared constants and the depth-code decoder of the fault queue.
// Assumes the depth code is always two bits wide.
package fq_pkg;
    localparam int MAX_DEPTH = 6;
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1);

    typedef logic [CNT_W-1:0] run_cnt_t;

    // Map the two-bit depth code to a run length (1, 2, 4, 6).
    function automatic run_cnt_t depth_of(input logic [1:0] code);
        case (code)
            2'b00:   return run_cnt_t'(1);
            2'b01:   return run_cnt_t'(2);
            2'b10:   return run_cnt_t'(4);
            default: return run_cnt_t'(MAX_DEPTH);
        endcase
    endfunction
endpackage

// File: rtl/fq_cmp.sv
// fq_cmp: signed window comparator for one zone.
// Produces a high candidate (value above the high limit) and a low candidate
// (value below the low limit). Equality is in-limit on both sides.
// Assumes all three operands are two's complement of the same width.
module fq_cmp #(
    parameter int TW = 12
) (
    input  logic [TW-1:0] value,
    input  logic [TW-1:0] hi_lim,
    input  logic [TW-1:0] lo_lim,
    output logic          above,
    output logic          below
);
    logic signed [TW-1:0] v_s, h_s, l_s;

    // Reinterpret operands as signed and compare.
    always_comb begin
        v_s   = signed'(value);
        h_s   = signed'(hi_lim);
        l_s   = signed'(lo_lim);
        above = (v_s > h_s);
        below = (v_s < l_s);
    end
endmodule

// File: rtl/fq_run_counter.sv
// fq_run_counter: counts consecutive candidate conversions for one condition.
// The qualified flag rises when the count reaches the depth. The count
// saturates there. A non-candidate conversion or a purge clears both.
// Assumes depth changes only together with a purge (configuration write).
module fq_run_counter
    import fq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     conv,
    input  logic     cand,
    input  logic     purge,
    input  run_cnt_t depth,
    output logic     qual
);
    run_cnt_t         cnt;
    logic [CNT_W:0]   cnt_inc;

    // Next count value, one bit wider so it never wraps.
    always_comb cnt_inc = {1'b0, cnt} + 1'b1;

    // Run counter and qualified flag update; purge has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (purge) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (conv) begin
            if (cand) begin
                if (cnt_inc >= {1'b0, depth}) begin
                    cnt  <= depth;
                    qual <= 1'b1;
                end else begin
                    cnt  <= cnt_inc[CNT_W-1:0];
                    qual <= 1'b0;
                end
            end else begin
                cnt  <= '0;
                qual <= 1'b0;
            end
        end
    end

    assert_purge_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (cnt == '0) && !qual);

    assert_break_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && !cand && !purge) |=> !qual);

    assert_rise_needs_cand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(conv && cand && !purge));

    assert_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && conv && cand && !purge) |=> qual);

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= run_cnt_t'(MAX_DEPTH));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv && !purge) |=> $stable(qual));
endmodule

// File: rtl/fq_zone.sv
// fq_zone: the whole filter path for one temperature zone. It holds the window
// comparator, independent high and low run counters, and unfiltered capture
// registers for the critical and diode-fault indications.
// Assumes purge already merges the global and the per-zone write strobes.
module fq_zone
    import fq_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv,
    input  logic [TW-1:0] value,
    input  logic [TW-1:0] hi_lim,
    input  logic [TW-1:0] lo_lim,
    input  logic          purge,
    input  run_cnt_t      depth,
    input  logic          crit_in,
    input  logic          diode_in,
    output logic          hi_evt,
    output logic          lo_evt,
    output logic          crit_evt,
    output logic          diode_evt
);
    logic above, below;

    fq_cmp #(.TW(TW)) u_cmp (
        .value  (value),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim),
        .above  (above),
        .below  (below)
    );

    fq_run_counter u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .conv  (conv),
        .cand  (above),
        .purge (purge),
        .depth (depth),
        .qual  (hi_evt)
    );

    fq_run_counter u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .conv  (conv),
        .cand  (below),
        .purge (purge),
        .depth (depth),
        .qual  (lo_evt)
    );

    // Capture the unfiltered indications on every conversion; purge does not apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_evt  <= 1'b0;
            diode_evt <= 1'b0;
        end else if (conv) begin
            crit_evt  <= crit_in;
            diode_evt <= diode_in;
        end
    end

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv |=> (crit_evt == $past(crit_in)) && (diode_evt == $past(diode_in)));

    assert_depth_one_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && above && !purge && depth == run_cnt_t'(1)) |=> hi_evt);

    assert_depth_one_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && below && !purge && depth == run_cnt_t'(1)) |=> lo_evt);
endmodule

// File: rtl/fault_queue_filter.sv
// fault_queue_filter: top of the multi-zone consecutive-event filter.
// Decodes the shared depth code, builds the per-zone purge from the
// configuration and limit write strobes, and instantiates one fq_zone per zone.
// Assumes the depth code changes only together with a cfg_wr pulse.
module fault_queue_filter
    import fq_pkg::*;
#(
    parameter int NZONE = 2,
    parameter int TW    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NZONE-1:0]    conv_done,
    input  logic [NZONE*TW-1:0] temp_flat,
    input  logic [NZONE*TW-1:0] hi_lim_flat,
    input  logic [NZONE*TW-1:0] lo_lim_flat,
    input  logic [1:0]          depth_sel,
    input  logic                cfg_wr,
    input  logic [NZONE-1:0]    hi_lim_wr,
    input  logic [NZONE-1:0]    lo_lim_wr,
    input  logic [NZONE-1:0]    crit_raw,
    input  logic [NZONE-1:0]    diode_raw,
    output logic [NZONE-1:0]    hi_evt,
    output logic [NZONE-1:0]    lo_evt,
    output logic [NZONE-1:0]    crit_evt,
    output logic [NZONE-1:0]    diode_evt
);
    run_cnt_t         depth;
    logic [NZONE-1:0] purge;

    // Decode the shared depth code once for all zones.
    always_comb depth = depth_of(depth_sel);

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        // Per-zone purge: global configuration write or this zone's limit writes.
        always_comb purge[z] = cfg_wr | hi_lim_wr[z] | lo_lim_wr[z];

        fq_zone #(.TW(TW)) u_zone (
            .clk       (clk),
            .rst_n     (rst_n),
            .conv      (conv_done[z]),
            .value     (temp_flat[z*TW +: TW]),
            .hi_lim    (hi_lim_flat[z*TW +: TW]),
            .lo_lim    (lo_lim_flat[z*TW +: TW]),
            .purge     (purge[z]),
            .depth     (depth),
            .crit_in   (crit_raw[z]),
            .diode_in  (diode_raw[z]),
            .hi_evt    (hi_evt[z]),
            .lo_evt    (lo_evt[z]),
            .crit_evt  (crit_evt[z]),
            .diode_evt (diode_evt[z])
        );

        assert_limit_purge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_lim_wr[z] || lo_lim_wr[z]) |=> !hi_evt[z] && !lo_evt[z]);
    end

    assert_cfg_purge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (hi_evt == '0) && (lo_evt == '0));
endmodule

// File: tb/sim_fault_queue_filter.sv
// Bench: a vector table walked by one loop, then directed corner-case tests.
module sim_fault_queue_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NZ = 2;
    localparam int TW = 12;
    localparam int NVEC = 20;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NZ-1:0]     conv_done, hi_lim_wr, lo_lim_wr, crit_raw, diode_raw;
    logic [NZ*TW-1:0]  temp_flat, hi_lim_flat, lo_lim_flat;
    logic [1:0]        depth_sel;
    logic              cfg_wr;
    logic [NZ-1:0]     hi_evt, lo_evt, crit_evt, diode_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_queue_filter #(.NZONE(NZ), .TW(TW)) u0 (
        .clk, .rst_n, .conv_done, .temp_flat, .hi_lim_flat, .lo_lim_flat,
        .depth_sel, .cfg_wr, .hi_lim_wr, .lo_lim_wr, .crit_raw, .diode_raw,
        .hi_evt, .lo_evt, .crit_evt, .diode_evt
    );

    // Entry: depth[29:28] t0[27:16] t1[15:4] exp_hi{z1,z0}[3:2] exp_lo{z1,z0}[1:0]
    // Limits: zone0 hi 0x190 (+25.0) lo 0x000; zone1 hi 0x050 (+5.0) lo 0xFF0 (-1.0)
    localparam logic [29:0] VEC [NVEC] = '{
        {2'd0, 12'h191, 12'h050, 2'b01, 2'b00},  // R1 just above / equal
        {2'd0, 12'h190, 12'hFEF, 2'b00, 2'b10},  // R1 equal, R2 -1.0625 < -1
        {2'd0, 12'hFFF, 12'hFF0, 2'b00, 2'b01},  // R2 signed -0.0625 < 0, equal
        {2'd0, 12'h800, 12'h7FF, 2'b10, 2'b01},  // R1 R2 extremes
        {2'd1, 12'h200, 12'h000, 2'b00, 2'b00},  // R3 depth 2, first
        {2'd1, 12'h200, 12'h000, 2'b01, 2'b00},  // R3 second
        {2'd1, 12'h200, 12'h000, 2'b01, 2'b00},  // R5 persists
        {2'd1, 12'h100, 12'h000, 2'b00, 2'b00},  // R4 break
        {2'd1, 12'h200, 12'h000, 2'b00, 2'b00},  // R4 run restarted
        {2'd2, 12'hF00, 12'h060, 2'b00, 2'b00},  // R3 depth 4: 1
        {2'd2, 12'hF00, 12'h060, 2'b00, 2'b00},  // 2
        {2'd2, 12'hF00, 12'h060, 2'b00, 2'b00},  // 3
        {2'd2, 12'hF00, 12'h060, 2'b10, 2'b01},  // 4 qualifies
        {2'd2, 12'hF00, 12'h040, 2'b00, 2'b01},  // R4 zone1 breaks, R5 zone0 holds
        {2'd3, 12'h300, 12'h800, 2'b00, 2'b00},  // R3 depth 6: 1
        {2'd3, 12'h300, 12'h800, 2'b00, 2'b00},
        {2'd3, 12'h300, 12'h800, 2'b00, 2'b00},
        {2'd3, 12'h300, 12'h800, 2'b00, 2'b00},
        {2'd3, 12'h300, 12'h800, 2'b00, 2'b00},  // 5
        {2'd3, 12'h300, 12'h800, 2'b01, 2'b10}   // 6 qualifies
    };

    // One clock: drive happens before, sampling at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        conv_done = '0; cfg_wr = 1'b0; hi_lim_wr = '0; lo_lim_wr = '0;
    endtask

    task automatic check(input string req, input logic [NZ-1:0] act, input logic [NZ-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_depth(input logic [1:0] d);
        depth_sel = d; cfg_wr = 1'b1;
        tick();
    endtask

    task automatic convert(input logic [TW-1:0] t0, input logic [TW-1:0] t1);
        temp_flat = {t1, t0}; conv_done = '1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; conv_done = '0; cfg_wr = 1'b0; hi_lim_wr = '0; lo_lim_wr = '0;
        crit_raw = '0; diode_raw = '0; depth_sel = 2'd0; temp_flat = '0;
        hi_lim_flat = {12'h050, 12'h190};
        lo_lim_flat = {12'hFF0, 12'h000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 hi", hi_evt, '0);
        check("R11 lo", lo_evt, '0);
        check("R11 crit/diode", crit_evt | diode_evt, '0);

        // Table walk; a depth change is applied with a configuration write.
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][29:28] != depth_sel) set_depth(VEC[i][29:28]);
            convert(VEC[i][27:16], VEC[i][15:4]);
            check($sformatf("R1/R2/R3 vec%0d hi", i), hi_evt, VEC[i][3:2]);
            check($sformatf("R2/R4/R5 vec%0d lo", i), lo_evt, VEC[i][1:0]);
        end

        // R7: a limit write purges only its own zone.
        set_depth(2'd1);
        convert(12'h200, 12'h100);
        check("R3 depth2 first", hi_evt, 2'b00);
        hi_lim_wr = 2'b01;
        tick();
        convert(12'h200, 12'h100);
        check("R7 zone0 purged zone1 kept", hi_evt, 2'b10);
        convert(12'h200, 12'h100);
        check("R7 zone0 recounts", hi_evt, 2'b11);

        // R6: a configuration write clears every zone.
        cfg_wr = 1'b1;
        tick();
        check("R6 cfg purge hi", hi_evt, 2'b00);

        // R8: purge in the same cycle as a strobe wins.
        set_depth(2'd0);
        depth_sel = 2'd0; cfg_wr = 1'b1; temp_flat = {12'h100, 12'h200}; conv_done = '1;
        tick();
        check("R8 purge beats strobe", hi_evt, 2'b00);
        convert(12'h200, 12'h100);
        check("R1 depth1 after purge", hi_evt, 2'b11);

        // R10: inputs change without a strobe; outputs hold.
        temp_flat = '0;
        tick(); tick(); tick();
        check("R10 hold without strobe", hi_evt, 2'b11);
        convert(12'h000, 12'h000);
        check("R4 in-limit clears", hi_evt, 2'b00);

        // R9: critical and diode pass through at depth 6.
        set_depth(2'd3);
        crit_raw = 2'b10; diode_raw = 2'b01;
        convert(12'h000, 12'h000);
        check("R9 crit first occurrence", crit_evt, 2'b10);
        check("R9 diode first occurrence", diode_evt, 2'b01);
        crit_raw = 2'b00; diode_raw = 2'b00;
        convert(12'h000, 12'h000);
        check("R9 crit cleared", crit_evt | diode_evt, 2'b00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule